// File: doc/BRIEF.md
# Decade Down Counter Built From Toggle Stages

This block is a synchronous 4-bit counter that counts down through the decimal digits. It starts at 9 and decrements by one on every rising clock edge. After it reaches 0, the next edge takes it back to 9, so the block has a ten-state cycle. It can serve as a digit divider or as a countdown timebase in a larger design. It has no enable input, so every edge counts.

Internally the block uses four toggle stages. A stage inverts its stored bit when its toggle enable is high and holds the bit otherwise. A small combinational network produces the four toggle enables. It sets a stage's enable exactly when that bit has to change between the present count and the next count. The least significant stage always toggles.

The most and least significant stages store their bits inverted, and the two middle stages store true values. Because of this, a register cleared to all zeros already represents 9. The output path re-inverts those two bits, so the visible count is plain binary. A terminal-count flag marks the cycle in which the count is 0.

Top module: `decade_down_ctr`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, the count after that edge is 9 (binary 1001). This holds no matter how many edges `rst` stays high.
- R2: With `rst` low, each rising edge changes a count of 1 to 9 into that value minus one.
- R3: With `rst` low, a rising edge at a count of 0 gives a count of 9.
- R4: `tc` is 1 in exactly the cycles in which `count` is 0, and 0 in all other cycles.
- R5: Starting from reset, the output repeats with a period of exactly ten edges: 9, 8, 7, 6, 5, 4, 3, 2, 1, 0, then 9 again. The count never shows a value above 9.
- R6: A reset applied at any point in the sequence, including the cycle with count 0, overrides the decrement. The count after that edge is 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all stages update on its rising edge |
| rst | input | 1 | Synchronous active-high reset; clears all stages, so the count is 9 |
| count | output | 4 | Present count in plain binary, from 9 down to 0 |
| tc | output | 1 | Terminal count; high while the count is 0 |

## Verification
A wrong toggle enable flips a stage at the wrong moment. The fault therefore shows at the ports on the very next edge, as a count that does not equal the previous count minus one. It can also show as a missed wrap from 0 to 9. A stage that stores its bit with the wrong polarity shows up right after the first reset, because the count then reads something other than 9. Walking three full wraps and then resetting from several positions exercises each enable equation in every legal state. Every such fault is therefore visible within one edge of the state where it occurs.

// File: rtl/decdn_pkg.sv
package decdn_pkg;

    localparam int unsigned CNT_W = 4;

    // Stage positions whose stored bit is the complement of the count bit.
    localparam logic [CNT_W-1:0] INV_MASK = 4'b1001;

    // Value seen at the output when every stage is cleared.
    localparam logic [CNT_W-1:0] TOP_VAL = INV_MASK;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic b3;
        logic b2;
        logic b1;
        logic b0;
    } stage_vec_t;

    function automatic cnt_t stored_to_count(input cnt_t stored);
        return stored ^ INV_MASK;
    endfunction

endpackage

// File: rtl/decdn_tstage.sv
module decdn_tstage (
    input  logic clk,
    input  logic rst,
    input  logic tgl,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (tgl) begin
            q <= ~q;
        end
    end

endmodule

// File: rtl/decdn_toggle_eqn.sv
module decdn_toggle_eqn
    import decdn_pkg::*;
(
    input  cnt_t stored,
    output cnt_t tgl
);

    stage_vec_t s;
    stage_vec_t t;

    always_comb begin
        s = stage_vec_t'(stored);
        // Bit 0 changes on every step of the sequence.
        t.b0 = 1'b1;
        // Bit 3 changes on the steps 8->7 and 0->9.
        t.b3 = s.b0 & ~s.b1 & ~s.b2;
        // Bit 2 changes on the steps 8->7 and 4->3.
        t.b2 = s.b0 & ~s.b1 & (~s.b3 | s.b2);
        // Bit 1 changes wherever bit 2 does, plus on 6->5 and 2->1.
        t.b1 = t.b2 | (s.b0 & s.b1);
        tgl  = cnt_t'(t);
    end

endmodule

// File: rtl/decade_down_ctr.sv
module decade_down_ctr
    import decdn_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] count,
    output logic             tc
);

    cnt_t stored;
    cnt_t tgl;

    decdn_toggle_eqn u_eqn (
        .stored (stored),
        .tgl    (tgl)
    );

    for (genvar g = 0; g < CNT_W; g++) begin : g_stage
        decdn_tstage u_stage (
            .clk (clk),
            .rst (rst),
            .tgl (tgl[g]),
            .q   (stored[g])
        );
    end

    always_comb begin
        count = stored_to_count(stored);
        tc    = (count == '0);
    end

endmodule

// File: rtl/decade_down_ctr_chk.sv
module decade_down_ctr_chk
    import decdn_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] count,
    input logic             tc
);

    logic armed = 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b1;
        end
    end

    a_r1_reset_nine: assert property (@(posedge clk) disable iff (!armed)
        rst |=> (count == TOP_VAL));

    a_r2_decrement: assert property (@(posedge clk) disable iff (!armed || rst)
        (count != '0) |=> (count == $past(count) - 4'd1));

    a_r3_wrap: assert property (@(posedge clk) disable iff (!armed || rst)
        (count == '0) |=> (count == TOP_VAL));

    a_r4_tc_zero: assert property (@(posedge clk) disable iff (!armed || rst)
        tc == (count == '0));

    a_r5_range: assert property (@(posedge clk) disable iff (!armed || rst)
        count <= TOP_VAL);

endmodule

bind decade_down_ctr decade_down_ctr_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .count (count),
    .tc    (tc)
);

// File: tb/decade_down_ctr_tb.sv
module decade_down_ctr_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] count;
    logic       tc;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Expected count after each edge following reset release.
    localparam logic [3:0] EXP_SEQ [10] = '{4'd8, 4'd7, 4'd6, 4'd5, 4'd4,
                                            4'd3, 4'd2, 4'd1, 4'd0, 4'd9};

    decade_down_ctr u_dut (
        .clk   (clk),
        .rst   (rst),
        .count (count),
        .tc    (tc)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic r);
        rst = r;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_to(input logic [3:0] target);
        for (int k = 0; k < 12 && count != target; k++) begin
            step(1'b0);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset held for several edges keeps the count at 9
        step(1'b1);
        check("R1 count", count, 4'd9);
        check("R4 tc", {3'b0, tc}, 4'd0);
        step(1'b1);
        step(1'b1);
        check("R1 held", count, 4'd9);

        // R2 R3 R4 R5: three full wraps from the vector table
        for (int i = 0; i < 30; i++) begin
            logic [3:0] e;
            e = EXP_SEQ[i % 10];
            step(1'b0);
            if (e == 4'd9) check("R3 wrap", count, e);
            else           check("R2 decrement", count, e);
            check("R4 tc", {3'b0, tc}, {3'b0, e == 4'd0});
            checks++;
            if (count > 4'd9) begin
                fails++;
                $display("FAIL R5 range: actual %0d expected <=9", count);
            end
        end
        check("R5 period", count, 4'd9);

        // R6: reset in the middle of the sequence
        run_to(4'd5);
        check("R6 setup", count, 4'd5);
        step(1'b1);
        check("R6 mid reset", count, 4'd9);

        // R6: reset on the terminal-count cycle takes precedence over the wrap
        run_to(4'd0);
        check("R4 tc at zero", {3'b0, tc}, 4'd1);
        step(1'b1);
        check("R6 reset at zero", count, 4'd9);
        check("R6 tc cleared", {3'b0, tc}, 4'd0);

        // R2: the count resumes from 9 after reset is released
        step(1'b0);
        check("R2 after reset", count, 4'd8);

        // R6: reset at count 1 (next edge would have given 0)
        run_to(4'd1);
        step(1'b1);
        check("R6 reset at one", count, 4'd9);
        step(1'b0);
        check("R2 resume", count, 4'd8);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule